// File: doc/BRIEF.md
# Retirement Debug Exception Generator

This block sits beside the retirement point of an instruction pipeline. It looks at each instruction as it retires and decides whether that instruction raises a debug exception. Two kinds of exception come out of it. A fault stops the instruction before it completes: an instruction-address breakpoint hit or a break instruction. A trap is raised after the instruction completes: single step, taken branch, or a branch that moves to a less privileged level. For every exception the block reports a cause code, the pointer at which execution should resume, and the pointer and slot of the instruction that raised it. A break fault also captures the immediate operand of the break instruction.

Instruction addresses are bundle addresses, and a slot index selects an instruction inside a bundle. The next instruction after the last slot is slot 0 of the following bundle. A bank of address comparators holds the breakpoints. Each comparator has an address, a mask of bits to ignore, and an enable.

A suppress-once flag can be armed from outside. It masks breakpoint faults for exactly one instruction and clears itself when an instruction completes. Flushing the pipeline and dispatching to the handler are done elsewhere.

Top module: `dbg_exc_unit`

## Requirements
- R1: With `en_step` high, every presented instruction that completes without a fault raises a trap with cause 5. The resume pointer is the next instruction: same address and slot+1, or, when the slot is the last slot (2), address+16 and slot 0. A predicated-off instruction still completes.
- R2: In alternate mode (`in_alt_mode`=1), `in_alt_tf`=1 also raises the single-step trap. It is ORed with `en_step`.
- R3: With `en_branch` high, a branch whose taken flag and predicate are both 1 raises a trap with cause 4. The resume pointer is the branch target at slot 0. A branch that is not taken raises nothing.
- R4: With `en_lowpriv` high, a taken branch whose target privilege is numerically greater than its current privilege raises a trap with cause 3, resuming at the target at slot 0. An equal or lower target privilege raises nothing, and so does alternate mode.
- R5: With `en_ibp` high, a fetch address matching an enabled comparator raises a fault with cause 1, even when the predicate is 0. The match rule is (addr & ~mask) == (bp_addr & ~mask). A disabled comparator never matches. A fault resumes at the faulting instruction itself.
- R6: A one-cycle `supp_set` pulse arms `supp_pending`, which masks breakpoint faults. It clears when an instruction completes. An instruction that faults leaves it armed.
- R7: A break instruction whose predicate is 1 raises a fault with cause 2 and loads `in_imm` into `exc_imm`. A break instruction whose predicate is 0 raises nothing.
- R8: A fault overrides every trap on the same instruction: `exc_trap_vec` reads 0 and `exc_is_fault` reads 1. A breakpoint fault outranks a break fault.
- R9: When several traps apply, the reported cause follows the order lower-privilege, then taken-branch, then single-step. `exc_trap_vec` shows every pending trap: bit 0 single step, bit 1 taken branch, bit 2 lower privilege.
- R10: All outputs are registered. `exc_valid` pulses for one cycle, in the cycle after the instruction is presented. The other outputs hold until the next exception. Reset clears every output and `supp_pending`.
- R11: The faulting pointer and slot always name the instruction that raised the exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction retires this cycle |
| in_addr | input | AW | Bundle address of the instruction |
| in_slot | input | SW | Slot index within the bundle |
| in_is_branch | input | 1 | Instruction is a branch |
| in_taken | input | 1 | Branch is taken |
| in_target | input | AW | Branch target bundle address |
| in_cur_pl | input | PLW | Current privilege level |
| in_tgt_pl | input | PLW | Privilege level after the branch |
| in_pred | input | 1 | Qualifying predicate value |
| in_is_break | input | 1 | Instruction is a break instruction |
| in_imm | input | IW | Break immediate operand |
| in_alt_mode | input | 1 | Alternate instruction-set mode |
| in_alt_tf | input | 1 | Alternate mode's own step flag |
| en_step | input | 1 | Single-step enable |
| en_branch | input | 1 | Taken-branch trap enable |
| en_lowpriv | input | 1 | Lower-privilege transfer trap enable |
| en_ibp | input | 1 | Instruction breakpoint enable |
| supp_set | input | 1 | Arm the suppress-once flag |
| bp_addr | input | NBP*AW | Comparator addresses, comparator i at bits [i*AW +: AW] |
| bp_mask | input | NBP*AW | Comparator don't-care masks |
| bp_en | input | NBP | Comparator enables |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_cause | output | 3 | 0 none, 1 breakpoint, 2 break, 3 lower privilege, 4 taken branch, 5 single step |
| exc_is_fault | output | 1 | Exception is a fault |
| exc_trap_vec | output | 3 | All pending trap causes |
| exc_resume_addr | output | AW | Resume bundle address |
| exc_resume_slot | output | SW | Resume slot |
| exc_fault_addr | output | AW | Address of the raising instruction |
| exc_fault_slot | output | SW | Slot of the raising instruction |
| exc_imm | output | IW | Captured break immediate |
| supp_pending | output | 1 | Suppress-once flag state |

## Verification
The bench looks for these corner cases, and each one gives a clear wrong result if the design gets it wrong:
- A single step from the last slot must wrap to the next bundle. A design without the wrap would resume at a slot that does not exist.
- A predicated-off branch or break must raise nothing, while a breakpoint hit on a predicated-off instruction must still fault. A design that mixes these up either misses the fault or raises a spurious one.
- A masked comparator must match only inside its window, and a disabled comparator must never match.
- A branch that meets all three trap conditions must report the lower-privilege cause with all three vector bits set.
- A fault must suppress every trap.
- The suppress-once flag must survive a faulting instruction and clear on the first completing one. A design that clears it on any retirement lets the next breakpoint hit go unseen.

// File: rtl/dbg_exc_pkg.sv
package dbg_exc_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_IBP  = 3'd1,
    CAUSE_BRK  = 3'd2,
    CAUSE_LPT  = 3'd3,
    CAUSE_TBR  = 3'd4,
    CAUSE_SST  = 3'd5
  } cause_e;

  localparam int TV_SST = 0;
  localparam int TV_TBR = 1;
  localparam int TV_LPT = 2;
  localparam int TV_W   = 3;
endpackage

// File: rtl/dbg_bp_bank.sv
module dbg_bp_bank #(
  parameter int NBP = 4,
  parameter int AW  = 32
) (
  input  logic [AW-1:0]     fetch_addr,
  input  logic [NBP*AW-1:0] bp_addr,
  input  logic [NBP*AW-1:0] bp_mask,
  input  logic [NBP-1:0]    bp_en,
  output logic              any_hit
);
  logic [NBP-1:0] hit_vec;

  // One masked comparator per breakpoint slot.
  for (genvar i = 0; i < NBP; i++) begin : g_cmp
    logic [AW-1:0] care;
    assign care       = ~bp_mask[i*AW +: AW];
    assign hit_vec[i] = bp_en[i] &&
                        ((fetch_addr & care) == (bp_addr[i*AW +: AW] & care));
  end

  assign any_hit = |hit_vec;
endmodule

// File: rtl/dbg_exc_eval.sv
module dbg_exc_eval
  import dbg_exc_pkg::*;
#(
  parameter int AW           = 32,
  parameter int SW           = 2,
  parameter int PLW          = 2,
  parameter int SLOTS        = 3,
  parameter int BUNDLE_BYTES = 16
) (
  input  logic            valid,
  input  logic [AW-1:0]   addr,
  input  logic [SW-1:0]   slot,
  input  logic            is_branch,
  input  logic            taken,
  input  logic [AW-1:0]   target,
  input  logic [PLW-1:0]  cur_pl,
  input  logic [PLW-1:0]  tgt_pl,
  input  logic            pred,
  input  logic            is_break,
  input  logic            alt_mode,
  input  logic            alt_tf,
  input  logic            en_step,
  input  logic            en_branch,
  input  logic            en_lowpriv,
  input  logic            en_ibp,
  input  logic            supp,
  input  logic            bp_hit,
  output logic            raise,
  output logic            is_fault,
  output logic            completes,
  output cause_e          cause,
  output logic [TV_W-1:0] trap_vec,
  output logic [AW-1:0]   resume_addr,
  output logic [SW-1:0]   resume_slot
);
  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);
  localparam logic [AW-1:0] STRIDE    = AW'(BUNDLE_BYTES);

  logic          fault_ibp, fault_brk, taken_eff;
  logic          step_on;
  logic [AW-1:0] next_addr;
  logic [SW-1:0] next_slot;

  // Fault conditions: the breakpoint fault ignores the predicate.
  always_comb begin
    fault_ibp = valid && en_ibp && bp_hit && !supp;
    fault_brk = valid && is_break && pred;
    is_fault  = fault_ibp || fault_brk;
    completes = valid && !is_fault;
  end

  // Trap conditions, only for instructions that complete.
  always_comb begin
    taken_eff        = is_branch && taken && pred;
    step_on          = en_step || (alt_mode && alt_tf);
    trap_vec         = '0;
    trap_vec[TV_SST] = completes && step_on;
    trap_vec[TV_TBR] = completes && en_branch && taken_eff;
    trap_vec[TV_LPT] = completes && en_lowpriv && taken_eff && !alt_mode &&
                       (tgt_pl > cur_pl);
    raise            = is_fault || (|trap_vec);
  end

  // Fixed priority: faults, then lower-privilege, taken-branch, step.
  always_comb begin
    if (fault_ibp)              cause = CAUSE_IBP;
    else if (fault_brk)         cause = CAUSE_BRK;
    else if (trap_vec[TV_LPT])  cause = CAUSE_LPT;
    else if (trap_vec[TV_TBR])  cause = CAUSE_TBR;
    else if (trap_vec[TV_SST])  cause = CAUSE_SST;
    else                        cause = CAUSE_NONE;
  end

  // Next sequential instruction, wrapping slot into the next bundle.
  always_comb begin
    if (slot >= LAST_SLOT) begin
      next_addr = addr + STRIDE;
      next_slot = '0;
    end else begin
      next_addr = addr;
      next_slot = slot + SW'(1);
    end
  end

  // Resume rule: faults re-execute, taken branches go to target.
  always_comb begin
    if (is_fault) begin
      resume_addr = addr;
      resume_slot = slot;
    end else if (taken_eff) begin
      resume_addr = target;
      resume_slot = '0;
    end else begin
      resume_addr = next_addr;
      resume_slot = next_slot;
    end
  end
endmodule

// File: rtl/dbg_exc_unit.sv
module dbg_exc_unit
  import dbg_exc_pkg::*;
#(
  parameter int AW           = 32,
  parameter int PLW          = 2,
  parameter int IW           = 21,
  parameter int NBP          = 4,
  parameter int SLOTS        = 3,
  parameter int BUNDLE_BYTES = 16,
  parameter int SW           = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [AW-1:0]     in_addr,
  input  logic [SW-1:0]     in_slot,
  input  logic              in_is_branch,
  input  logic              in_taken,
  input  logic [AW-1:0]     in_target,
  input  logic [PLW-1:0]    in_cur_pl,
  input  logic [PLW-1:0]    in_tgt_pl,
  input  logic              in_pred,
  input  logic              in_is_break,
  input  logic [IW-1:0]     in_imm,
  input  logic              in_alt_mode,
  input  logic              in_alt_tf,
  input  logic              en_step,
  input  logic              en_branch,
  input  logic              en_lowpriv,
  input  logic              en_ibp,
  input  logic              supp_set,
  input  logic [NBP*AW-1:0] bp_addr,
  input  logic [NBP*AW-1:0] bp_mask,
  input  logic [NBP-1:0]    bp_en,
  output logic              exc_valid,
  output logic [2:0]        exc_cause,
  output logic              exc_is_fault,
  output logic [TV_W-1:0]   exc_trap_vec,
  output logic [AW-1:0]     exc_resume_addr,
  output logic [SW-1:0]     exc_resume_slot,
  output logic [AW-1:0]     exc_fault_addr,
  output logic [SW-1:0]     exc_fault_slot,
  output logic [IW-1:0]     exc_imm,
  output logic              supp_pending
);
  logic            bp_hit;
  logic            ev_raise, ev_fault, ev_done;
  cause_e          ev_cause;
  logic [TV_W-1:0] ev_vec;
  logic [AW-1:0]   ev_raddr;
  logic [SW-1:0]   ev_rslot;

  logic            supp_q, supp_d;
  logic            load_exc, load_imm;

  dbg_bp_bank #(.NBP(NBP), .AW(AW)) u_bp (
    .fetch_addr (in_addr),
    .bp_addr    (bp_addr),
    .bp_mask    (bp_mask),
    .bp_en      (bp_en),
    .any_hit    (bp_hit)
  );

  dbg_exc_eval #(
    .AW(AW), .SW(SW), .PLW(PLW), .SLOTS(SLOTS), .BUNDLE_BYTES(BUNDLE_BYTES)
  ) u_eval (
    .valid       (in_valid),
    .addr        (in_addr),
    .slot        (in_slot),
    .is_branch   (in_is_branch),
    .taken       (in_taken),
    .target      (in_target),
    .cur_pl      (in_cur_pl),
    .tgt_pl      (in_tgt_pl),
    .pred        (in_pred),
    .is_break    (in_is_break),
    .alt_mode    (in_alt_mode),
    .alt_tf      (in_alt_tf),
    .en_step     (en_step),
    .en_branch   (en_branch),
    .en_lowpriv  (en_lowpriv),
    .en_ibp      (en_ibp),
    .supp        (supp_q),
    .bp_hit      (bp_hit),
    .raise       (ev_raise),
    .is_fault    (ev_fault),
    .completes   (ev_done),
    .cause       (ev_cause),
    .trap_vec    (ev_vec),
    .resume_addr (ev_raddr),
    .resume_slot (ev_rslot)
  );

  // Next-state: suppress flag and clock enables for the capture registers.
  always_comb begin
    if (supp_set)     supp_d = 1'b1;
    else if (ev_done) supp_d = 1'b0;
    else              supp_d = supp_q;
    load_exc = ev_raise;
    load_imm = ev_fault && (ev_cause == CAUSE_BRK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      supp_q    <= 1'b0;
      exc_valid <= 1'b0;
    end else begin
      supp_q    <= supp_d;
      exc_valid <= ev_raise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_cause       <= CAUSE_NONE;
      exc_is_fault    <= 1'b0;
      exc_trap_vec    <= '0;
      exc_resume_addr <= '0;
      exc_resume_slot <= '0;
      exc_fault_addr  <= '0;
      exc_fault_slot  <= '0;
    end else if (load_exc) begin
      exc_cause       <= ev_cause;
      exc_is_fault    <= ev_fault;
      exc_trap_vec    <= ev_vec;
      exc_resume_addr <= ev_raddr;
      exc_resume_slot <= ev_rslot;
      exc_fault_addr  <= in_addr;
      exc_fault_slot  <= in_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        exc_imm <= '0;
    else if (load_imm) exc_imm <= in_imm;
  end

  assign supp_pending = supp_q;

  // Assertions
  assert_pulse_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> $past(in_valid));

  assert_fault_masks_traps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_is_fault) |-> (exc_trap_vec == '0));

  assert_trap_has_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !exc_is_fault) |-> ((exc_trap_vec != '0) && (exc_cause >= 3'd3)));

  assert_fault_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_is_fault) |->
      ((exc_resume_addr == exc_fault_addr) && (exc_resume_slot == exc_fault_slot)));

  assert_break_imm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_cause == 3'd2) |-> (exc_imm == $past(in_imm)));

  assert_supp_survives_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (supp_q && in_valid && in_is_break && in_pred && !supp_set) |=> supp_q);

  assert_fault_ptr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_fault_addr == $past(in_addr) && exc_fault_slot == $past(in_slot)));
endmodule

// File: tb/dbg_exc_unit_bench.sv
`timescale 1ns/1ps
module dbg_exc_unit_bench;
  localparam int AW = 32, PLW = 2, IW = 21, NBP = 4, SW = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid, in_is_branch, in_taken, in_pred, in_is_break;
  logic [AW-1:0]     in_addr, in_target;
  logic [SW-1:0]     in_slot;
  logic [PLW-1:0]    in_cur_pl, in_tgt_pl;
  logic [IW-1:0]     in_imm;
  logic              in_alt_mode, in_alt_tf;
  logic              en_step, en_branch, en_lowpriv, en_ibp, supp_set;
  logic [NBP*AW-1:0] bp_addr, bp_mask;
  logic [NBP-1:0]    bp_en;
  logic              exc_valid, exc_is_fault, supp_pending;
  logic [2:0]        exc_cause, exc_trap_vec;
  logic [AW-1:0]     exc_resume_addr, exc_fault_addr;
  logic [SW-1:0]     exc_resume_slot, exc_fault_slot;
  logic [IW-1:0]     exc_imm;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dbg_exc_unit u_dbg_exc_unit (.*);

  typedef struct packed {
    logic [31:0] addr;  logic [1:0] slot; logic br; logic tk;
    logic [31:0] tgt;   logic [1:0] cpl;  logic [1:0] tpl;
    logic pred; logic brk; logic [20:0] imm; logic alt; logic tf;
    logic [3:0] en;     // {step, branch, lowpriv, ibp}
    logic xv; logic [2:0] xc; logic [31:0] xra; logic [1:0] xrs; logic [2:0] xvec;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VT [NV] = '{
    '{32'h100,2'd0,1'b0,1'b0,32'h0,2'd0,2'd0,1'b1,1'b0,21'h0,1'b0,1'b0,4'b1000, 1'b1,3'd5,32'h100,2'd1,3'b001},
    '{32'h110,2'd2,1'b0,1'b0,32'h0,2'd0,2'd0,1'b1,1'b0,21'h0,1'b0,1'b0,4'b1000, 1'b1,3'd5,32'h120,2'd0,3'b001},
    '{32'h130,2'd1,1'b0,1'b0,32'h0,2'd0,2'd0,1'b1,1'b0,21'h0,1'b0,1'b0,4'b0000, 1'b0,3'd0,32'h0,2'd0,3'b000},
    '{32'h200,2'd1,1'b1,1'b1,32'h400,2'd0,2'd0,1'b1,1'b0,21'h0,1'b0,1'b0,4'b0100, 1'b1,3'd4,32'h400,2'd0,3'b010},
    '{32'h210,2'd0,1'b1,1'b0,32'h400,2'd0,2'd0,1'b1,1'b0,21'h0,1'b0,1'b0,4'b0100, 1'b0,3'd0,32'h0,2'd0,3'b000},
    '{32'h220,2'd0,1'b1,1'b1,32'h500,2'd0,2'd3,1'b1,1'b0,21'h0,1'b0,1'b0,4'b0010, 1'b1,3'd3,32'h500,2'd0,3'b100},
    '{32'h230,2'd0,1'b1,1'b1,32'h500,2'd2,2'd2,1'b1,1'b0,21'h0,1'b0,1'b0,4'b0010, 1'b0,3'd0,32'h0,2'd0,3'b000},
    '{32'h240,2'd0,1'b1,1'b1,32'h500,2'd3,2'd1,1'b1,1'b0,21'h0,1'b0,1'b0,4'b0010, 1'b0,3'd0,32'h0,2'd0,3'b000},
    '{32'h250,2'd0,1'b1,1'b1,32'h500,2'd0,2'd3,1'b1,1'b0,21'h0,1'b1,1'b0,4'b0010, 1'b0,3'd0,32'h0,2'd0,3'b000},
    '{32'h260,2'd1,1'b0,1'b0,32'h0,2'd0,2'd0,1'b1,1'b0,21'h0,1'b1,1'b1,4'b0000, 1'b1,3'd5,32'h260,2'd2,3'b001},
    '{32'h270,2'd0,1'b1,1'b1,32'h600,2'd1,2'd2,1'b1,1'b0,21'h0,1'b0,1'b0,4'b1110, 1'b1,3'd3,32'h600,2'd0,3'b111},
    '{32'h280,2'd0,1'b1,1'b1,32'h600,2'd0,2'd0,1'b0,1'b0,21'h0,1'b0,1'b0,4'b1100, 1'b1,3'd5,32'h280,2'd1,3'b001},
    '{32'h1000,2'd2,1'b0,1'b0,32'h0,2'd0,2'd0,1'b1,1'b0,21'h0,1'b0,1'b0,4'b0001, 1'b1,3'd1,32'h1000,2'd2,3'b000},
    '{32'h1000,2'd1,1'b0,1'b0,32'h0,2'd0,2'd0,1'b0,1'b0,21'h0,1'b0,1'b0,4'b0001, 1'b1,3'd1,32'h1000,2'd1,3'b000},
    '{32'h200C,2'd0,1'b0,1'b0,32'h0,2'd0,2'd0,1'b1,1'b0,21'h0,1'b0,1'b0,4'b0001, 1'b1,3'd1,32'h200C,2'd0,3'b000},
    '{32'h2010,2'd0,1'b0,1'b0,32'h0,2'd0,2'd0,1'b1,1'b0,21'h0,1'b0,1'b0,4'b0001, 1'b0,3'd0,32'h0,2'd0,3'b000},
    '{32'h3000,2'd0,1'b0,1'b0,32'h0,2'd0,2'd0,1'b1,1'b0,21'h0,1'b0,1'b0,4'b0001, 1'b0,3'd0,32'h0,2'd0,3'b000},
    '{32'h1000,2'd0,1'b0,1'b0,32'h0,2'd0,2'd0,1'b1,1'b0,21'h0,1'b0,1'b0,4'b0000, 1'b0,3'd0,32'h0,2'd0,3'b000},
    '{32'h700,2'd1,1'b0,1'b0,32'h0,2'd0,2'd0,1'b1,1'b1,21'h5A5,1'b0,1'b0,4'b1000, 1'b1,3'd2,32'h700,2'd1,3'b000},
    '{32'h710,2'd0,1'b0,1'b0,32'h0,2'd0,2'd0,1'b0,1'b1,21'h333,1'b0,1'b0,4'b0000, 1'b0,3'd0,32'h0,2'd0,3'b000},
    '{32'h1000,2'd0,1'b0,1'b0,32'h0,2'd0,2'd0,1'b1,1'b1,21'h111,1'b0,1'b0,4'b0001, 1'b1,3'd1,32'h1000,2'd0,3'b000},
    '{32'h2008,2'd0,1'b1,1'b1,32'h900,2'd0,2'd1,1'b1,1'b0,21'h0,1'b0,1'b0,4'b1111, 1'b1,3'd1,32'h2008,2'd0,3'b000}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 0; in_is_branch = 0; in_taken = 0; in_pred = 1; in_is_break = 0;
    in_addr = '0; in_target = '0; in_slot = '0; in_cur_pl = '0; in_tgt_pl = '0;
    in_imm = '0; in_alt_mode = 0; in_alt_tf = 0;
  endtask

  // Present one instruction for a single cycle; return at the next negedge,
  // when the registered result is visible.
  task automatic present(input vec_t v);
    @(negedge clk);
    in_valid = 1; in_addr = v.addr; in_slot = v.slot; in_is_branch = v.br;
    in_taken = v.tk; in_target = v.tgt; in_cur_pl = v.cpl; in_tgt_pl = v.tpl;
    in_pred = v.pred; in_is_break = v.brk; in_imm = v.imm; in_alt_mode = v.alt;
    in_alt_tf = v.tf;
    {en_step, en_branch, en_lowpriv, en_ibp} = v.en;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic check_vec(input vec_t v, input string req);
    chk(exc_valid == v.xv, req, 64'(exc_valid), 64'(v.xv));
    if (v.xv) begin
      chk(exc_cause == v.xc, req, 64'(exc_cause), 64'(v.xc));
      chk(exc_resume_addr == v.xra && exc_resume_slot == v.xrs, req,
          {exc_resume_addr, 30'd0, exc_resume_slot}, {v.xra, 30'd0, v.xrs});
      chk(exc_trap_vec == v.xvec, req, 64'(exc_trap_vec), 64'(v.xvec));
      // R11: faulting pointer names the raising instruction
      chk(exc_fault_addr == v.addr && exc_fault_slot == v.slot, "R11",
          {exc_fault_addr, 30'd0, exc_fault_slot}, {v.addr, 30'd0, v.slot});
      chk(exc_is_fault == (v.xc <= 3'd2), "R8", 64'(exc_is_fault), 64'(v.xc <= 3'd2));
      if (v.xc == 3'd2) chk(exc_imm == v.imm, "R7", 64'(exc_imm), 64'(v.imm));
    end
  endtask

  function automatic vec_t mk(input logic [31:0] a, input logic p, input logic b,
                              input logic [20:0] im, input logic [3:0] en);
    vec_t v = '0;
    v.addr = a; v.pred = p; v.brk = b; v.imm = im; v.en = en;
    return v;
  endfunction

  initial begin : watchdog
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    vec_t v;
    idle_inputs();
    en_step = 0; en_branch = 0; en_lowpriv = 0; en_ibp = 0; supp_set = 0;
    bp_addr = {32'h0, 32'h3000, 32'h2000, 32'h1000};
    bp_mask = {32'h0, 32'h0, 32'h0000000F, 32'h0};
    bp_en   = 4'b0011;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10: reset state
    chk(exc_valid == 0 && exc_cause == 0 && exc_imm == 0 && supp_pending == 0 &&
        exc_resume_addr == 0, "R10",
        {exc_valid, exc_cause, supp_pending}, 64'h0);

    // Table walk covering R1 R2 R3 R4 R5 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      present(VT[i]);
      check_vec(VT[i], $sformatf("vector %0d (R1..R9 table)", i));
    end

    // R10: single-cycle pulse, held fields
    present(VT[0]);
    chk(exc_valid == 1, "R10", 64'(exc_valid), 64'd1);
    @(negedge clk);
    chk(exc_valid == 0, "R10", 64'(exc_valid), 64'd0);
    chk(exc_cause == 3'd5 && exc_resume_addr == 32'h100, "R10",
        {exc_cause, exc_resume_addr}, {3'd5, 32'h100});

    // R6: arm suppress-once
    @(negedge clk); supp_set = 1;
    @(negedge clk); supp_set = 0;
    chk(supp_pending == 1, "R6", 64'(supp_pending), 64'd1);
    // R6/R8: a break fault leaves the flag armed
    v = mk(32'h720, 1'b1, 1'b1, 21'h0AB, 4'b0000);
    present(v);
    chk(exc_valid == 1 && exc_cause == 3'd2, "R6", 64'(exc_cause), 64'd2);
    chk(supp_pending == 1, "R6", 64'(supp_pending), 64'd1);
    chk(exc_imm == 21'h0AB, "R7", 64'(exc_imm), 64'h0AB);
    // R6: breakpoint hit is masked, flag clears on completion
    v = mk(32'h1000, 1'b1, 1'b0, 21'h0, 4'b0001);
    present(v);
    chk(exc_valid == 0, "R6", 64'(exc_valid), 64'd0);
    chk(supp_pending == 0, "R6", 64'(supp_pending), 64'd0);
    // R6: next hit faults again
    present(v);
    chk(exc_valid == 1 && exc_cause == 3'd1, "R6", 64'(exc_cause), 64'd1);
    // R7: imm unchanged by a breakpoint fault
    chk(exc_imm == 21'h0AB, "R7", 64'(exc_imm), 64'h0AB);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule